// File: doc/BRIEF.md
# Self-Routing Banyan Switch Fabric

This block moves up to N packets per clock from N input ports to N output ports through a network of log2(N) stages. Each stage holds N/2 two-by-two switching elements, (N/2)·log2(N) elements in all. Nothing schedules the packets centrally and there is no lookup table. Each element decides its own setting, bar or cross, from one bit of the destination address of each packet that reaches it. A packet's route is therefore fixed by its destination alone.

The network is blocking. Two packets bound for different outputs can still need the same internal link. When that happens, the element lets one packet through and drops the other, and the dropped packet's input port sees a blocked flag. The fabric does not buffer or retry. A source that sees its blocked flag decides for itself whether to send the packet again.

Inside the fabric only a valid bit and the original input index travel through the stages. The payload is picked from the input bus by that index at the output. The whole path is combinational up to one output register, so results appear one clock after the inputs.

Top module: `banyan_fabric`

## Requirements
- R1: A valid packet on input i with destination d that is not blocked appears as `port_valid[d]` = 1 with `port_data[d]` equal to its payload on the first rising clock edge after it is applied, and not before that edge.
- R2: Lanes are numbered 0..N-1, and input port i enters on lane i. Stage k (k = 0 first) pairs the lanes whose indices differ only in bit k. It steers on destination bit log2(N)-1-k (most significant bit first). A 0 sends the packet to the lane with bit k clear (upper), and a 1 sends it to the lane with bit k set (lower). Output port p is fed by the lane whose index is p bit-reversed. Conflict-free permutations are delivered in full.
- R3: When both packets at an element are valid and ask for the same side, the packet on the upper lane passes and the lower one is dropped. For N=8, input 0 to output 4 together with input 1 to output 5 collide: output 4 is delivered and `pkt_blocked[1]` rises.
- R4: An input with valid low takes no part in arbitration, so it never blocks another packet. An output whose valid is low presents an all-zero payload whatever the inputs carry.
- R5: `pkt_blocked[i]` is raised only for an input that was valid. Every valid input is either delivered or blocked, never both.
- R6: While `rst_n` is low (asynchronous, active low), all of `port_valid`, `port_data` and `pkt_blocked` are zero.
- R7: A packet dropped at any stage, including the middle and last stages, is reported on the blocked flag of its original input port.
- R8: Each cycle stands alone. A blocked or delivered packet leaves no trace in the outputs one cycle after its inputs are withdrawn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pkt_valid | input | NPORTS | Packet present on each input port |
| pkt_dest | input | NPORTS x log2(NPORTS) | Destination port of each input packet |
| pkt_data | input | NPORTS x DATA_W | Payload of each input packet |
| port_valid | output | NPORTS | Packet delivered on each output port |
| port_data | output | NPORTS x DATA_W | Payload on each output port, zero when idle |
| pkt_blocked | output | NPORTS | Input packet dropped by a conflict, per input port |

## Verification
A lane paired on the wrong index bit, or steered on the wrong destination bit, shows up in the same cycle's registered result. Either a packet lands on an output other than its destination, or a conflict-free permutation reports a spurious block on some input. A wrong arbitration winner or a lost source index shows up as the blocked flag on the wrong input, or as a payload taken from the wrong input. Both appear one clock after the stimulus. The stimulus puts collisions at the first, middle and last stage so that each stage's pairing is seen alone at the ports.

// File: rtl/banyan_pkg.sv
package banyan_pkg;

   // Reverse the low 'width' bits of 'value'
   function automatic int unsigned bit_rev(input int unsigned value, input int unsigned width);
      int unsigned res;
      res = 0;
      for (int unsigned b = 0; b < width; b++) begin
         if (((value >> b) & 1) != 0) res = res | (1 << (width - 1 - b));
      end
      return res;
   endfunction

   // Element j of a stage: lane index with a 0 inserted at bit position 'pos'
   function automatic int unsigned pair_lo(input int unsigned j, input int unsigned pos);
      return ((j >> pos) << (pos + 1)) | (j & ((1 << pos) - 1));
   endfunction

endpackage

// File: rtl/banyan_elem.sv
module banyan_elem #(
   parameter int AW = 3
) (
   input  logic [1:0]         in_vld,
   input  logic [1:0]         in_want,
   input  logic [1:0][AW-1:0] in_src,
   output logic [1:0]         out_vld,
   output logic [1:0][AW-1:0] out_src,
   output logic               drop,
   output logic [AW-1:0]      drop_src
);

   // in_want[x] = 0 asks for the upper side, 1 for the lower side
   always_comb begin
      out_vld  = '0;
      out_src  = '0;
      drop     = 1'b0;
      drop_src = '0;
      if (in_vld[0]) begin
         out_vld[in_want[0]] = 1'b1;
         out_src[in_want[0]] = in_src[0];
      end
      if (in_vld[1]) begin
         if (in_vld[0] && (in_want[0] == in_want[1])) begin
            drop     = 1'b1;
            drop_src = in_src[1];
         end else begin
            out_vld[in_want[1]] = 1'b1;
            out_src[in_want[1]] = in_src[1];
         end
      end
   end

endmodule

// File: rtl/banyan_stage.sv
module banyan_stage
   import banyan_pkg::*;
#(
   parameter int NPORTS = 8,
   parameter int LEVEL  = 0
) (
   input  logic [NPORTS-1:0][$clog2(NPORTS)-1:0] dest_tab,
   input  logic [NPORTS-1:0]                     in_vld,
   input  logic [NPORTS-1:0][$clog2(NPORTS)-1:0] in_src,
   output logic [NPORTS-1:0]                     out_vld,
   output logic [NPORTS-1:0][$clog2(NPORTS)-1:0] out_src,
   output logic [NPORTS-1:0]                     blk
);

   localparam int AW    = $clog2(NPORTS);
   localparam int HALF  = NPORTS / 2;
   localparam int RBIT  = AW - 1 - LEVEL;
   localparam int SPAN  = 1 << LEVEL;

   logic [HALF-1:0]         e_drop;
   logic [HALF-1:0][AW-1:0] e_dsrc;

   for (genvar j = 0; j < HALF; j++) begin : g_elem
      localparam int LO = pair_lo(j, LEVEL);
      localparam int HI = LO + SPAN;

      logic [1:0]         want;
      logic [1:0]         ov;
      logic [1:0][AW-1:0] os;

      // destination looked up through the carried source index
      assign want = {dest_tab[in_src[HI]][RBIT], dest_tab[in_src[LO]][RBIT]};

      banyan_elem #(.AW(AW)) u_elem (
         .in_vld   ({in_vld[HI], in_vld[LO]}),
         .in_want  (want),
         .in_src   ({in_src[HI], in_src[LO]}),
         .out_vld  (ov),
         .out_src  (os),
         .drop     (e_drop[j]),
         .drop_src (e_dsrc[j])
      );

      assign out_vld[LO] = ov[0];
      assign out_vld[HI] = ov[1];
      assign out_src[LO] = os[0];
      assign out_src[HI] = os[1];
   end

   always_comb begin
      blk = '0;
      for (int j = 0; j < HALF; j++) begin
         if (e_drop[j]) blk[e_dsrc[j]] = 1'b1;
      end
   end

endmodule

// File: rtl/banyan_fabric.sv
module banyan_fabric
   import banyan_pkg::*;
#(
   parameter int NPORTS = 8,
   parameter int DATA_W = 8
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [NPORTS-1:0]                     pkt_valid,
   input  logic [NPORTS-1:0][$clog2(NPORTS)-1:0] pkt_dest,
   input  logic [NPORTS-1:0][DATA_W-1:0]         pkt_data,
   output logic [NPORTS-1:0]                     port_valid,
   output logic [NPORTS-1:0][DATA_W-1:0]         port_data,
   output logic [NPORTS-1:0]                     pkt_blocked
);

   localparam int AW     = $clog2(NPORTS);
   localparam int STAGES = AW;

   if (NPORTS < 2 || (NPORTS & (NPORTS - 1)) != 0) begin : g_bad_nports
      $error("banyan_fabric: NPORTS must be a power of two, at least 2");
   end
   if (NPORTS > 1024) begin : g_big_nports
      $error("banyan_fabric: NPORTS above 1024 not supported");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("banyan_fabric: DATA_W must be at least 1");
   end

   logic [STAGES:0][NPORTS-1:0]         s_vld;
   logic [STAGES:0][NPORTS-1:0][AW-1:0] s_src;
   logic [STAGES-1:0][NPORTS-1:0]       s_blk;

   assign s_vld[0] = pkt_valid;
   for (genvar i = 0; i < NPORTS; i++) begin : g_tag
      assign s_src[0][i] = AW'(i);
   end

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      banyan_stage #(.NPORTS(NPORTS), .LEVEL(k)) u_stage (
         .dest_tab (pkt_dest),
         .in_vld   (s_vld[k]),
         .in_src   (s_src[k]),
         .out_vld  (s_vld[k+1]),
         .out_src  (s_src[k+1]),
         .blk      (s_blk[k])
      );
   end

   logic [NPORTS-1:0]             nxt_vld;
   logic [NPORTS-1:0][DATA_W-1:0] nxt_dat;
   logic [NPORTS-1:0]             nxt_blk;

   for (genvar p = 0; p < NPORTS; p++) begin : g_out
      localparam int LANE = bit_rev(p, AW);
      assign nxt_vld[p] = s_vld[STAGES][LANE];
      assign nxt_dat[p] = s_vld[STAGES][LANE] ? pkt_data[s_src[STAGES][LANE]] : '0;
   end

   always_comb begin
      nxt_blk = '0;
      for (int k = 0; k < STAGES; k++) nxt_blk = nxt_blk | s_blk[k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         port_valid  <= '0;
         port_data   <= '0;
         pkt_blocked <= '0;
      end else begin
         port_valid  <= nxt_vld;
         port_data   <= nxt_dat;
         pkt_blocked <= nxt_blk;
      end
   end

endmodule

// File: rtl/banyan_chk.sv
module banyan_chk #(
   parameter int NPORTS = 8,
   parameter int DATA_W = 8
) (
   input logic                                 clk,
   input logic                                 rst_n,
   input logic [NPORTS-1:0]                     pkt_valid,
   input logic [NPORTS-1:0][$clog2(NPORTS)-1:0] pkt_dest,
   input logic [NPORTS-1:0][DATA_W-1:0]         pkt_data,
   input logic [NPORTS-1:0]                     port_valid,
   input logic [NPORTS-1:0][DATA_W-1:0]         port_data,
   input logic [NPORTS-1:0]                     pkt_blocked
);

   localparam int AW = $clog2(NPORTS);

   logic                             armed;
   logic [NPORTS-1:0]                vld_q;
   logic [NPORTS-1:0][AW-1:0]        dst_q;
   logic [NPORTS-1:0][DATA_W-1:0]    dat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   always_ff @(posedge clk) begin
      vld_q <= pkt_valid;
      dst_q <= pkt_dest;
      dat_q <= pkt_data;
   end

   AST_CONSERVE: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> ($countones(port_valid) + $countones(pkt_blocked) == $countones(vld_q))); // R5

   for (genvar i = 0; i < NPORTS; i++) begin : g_in
      AST_DELIVER: assert property (@(posedge clk) disable iff (!rst_n)
         armed && vld_q[i] && !pkt_blocked[i] |->
            port_valid[dst_q[i]] && (port_data[dst_q[i]] == dat_q[i])); // R1
      AST_BLOCK_VALID: assert property (@(posedge clk) disable iff (!rst_n)
         armed && pkt_blocked[i] |-> vld_q[i]); // R5
   end

   for (genvar p = 0; p < NPORTS; p++) begin : g_port
      AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         !port_valid[p] |-> (port_data[p] == '0)); // R4
   end

   for (genvar j = 0; j < NPORTS / 2; j++) begin : g_first
      AST_UPPER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         armed && vld_q[2*j] && vld_q[2*j+1] &&
         (dst_q[2*j][AW-1] == dst_q[2*j+1][AW-1]) |-> pkt_blocked[2*j+1]); // R3
   end

endmodule

bind banyan_fabric banyan_chk #(.NPORTS(NPORTS), .DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pkt_valid   (pkt_valid),
   .pkt_dest    (pkt_dest),
   .pkt_data    (pkt_data),
   .port_valid  (port_valid),
   .port_data   (port_data),
   .pkt_blocked (pkt_blocked)
);

// File: tb/test_banyan_fabric.sv
module test_banyan_fabric;

   localparam int N  = 8;
   localparam int AW = 3;
   localparam int DW = 8;
   localparam int NV = 10;

   // {valid[7:0], dest{p7..p0}[23:0], expected port_valid[7:0], expected blocked[7:0]}
   localparam logic [47:0] VEC [NV] = '{
      {8'hFF, {3'd7,3'd3,3'd5,3'd1,3'd6,3'd2,3'd4,3'd0}, 8'hFF, 8'h00}, // R2 straight
      {8'hFF, {3'd3,3'd7,3'd1,3'd5,3'd2,3'd6,3'd0,3'd4}, 8'hFF, 8'h00}, // R2 crossed
      {8'h03, {3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd5,3'd4}, 8'h10, 8'h02}, // R3 0->4,1->5
      {8'h05, {3'd0,3'd0,3'd0,3'd0,3'd0,3'd1,3'd0,3'd0}, 8'h01, 8'h04}, // R7 middle stage
      {8'h11, {3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd0}, 8'h01, 8'h10}, // R7 last stage
      {8'h02, {3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd4,3'd4}, 8'h10, 8'h00}, // R4 idle partner
      {8'hFF, {3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd0}, 8'h01, 8'hFE}, // R7 all to 0
      {8'h00, {3'd1,3'd2,3'd3,3'd4,3'd5,3'd6,3'd7,3'd0}, 8'h00, 8'h00}, // R8 idle after
      {8'hFF, {3'd7,3'd7,3'd7,3'd7,3'd7,3'd7,3'd7,3'd7}, 8'h80, 8'hFE}, // R7 all to 7
      {8'h0C, {3'd0,3'd0,3'd0,3'd0,3'd7,3'd6,3'd0,3'd0}, 8'h40, 8'h08}  // R3 2->6,3->7
   };

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic [N-1:0]            pkt_valid = '0;
   logic [N-1:0][AW-1:0]    pkt_dest = '0;
   logic [N-1:0][DW-1:0]    pkt_data = '0;
   logic [N-1:0]            port_valid;
   logic [N-1:0][DW-1:0]    port_data;
   logic [N-1:0]            pkt_blocked;

   int  checks = 0;
   int  errors = 0;
   bit  done   = 1'b0;

   always #10 clk = ~clk;

   banyan_fabric #(.NPORTS(N), .DATA_W(DW)) i_banyan_fabric (
      .clk         (clk),
      .rst_n       (rst_n),
      .pkt_valid   (pkt_valid),
      .pkt_dest    (pkt_dest),
      .pkt_data    (pkt_data),
      .port_valid  (port_valid),
      .port_data   (port_data),
      .pkt_blocked (pkt_blocked)
   );

   function automatic string req_of(input int v);
      case (v)
         0, 1:       return "R2";
         2, 9:       return "R3";
         5:          return "R4";
         7:          return "R8";
         default:    return "R7";
      endcase
   endfunction

   function automatic logic [DW-1:0] dat_of(input int v, input int i);
      return DW'((v + 1) * 16 + i);
   endfunction

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic drive(input int v);
      pkt_valid = VEC[v][47:40];
      pkt_dest  = VEC[v][39:16];
      for (int i = 0; i < N; i++) pkt_data[i] = dat_of(v, i);
   endtask

   task automatic check_vec(input int v);
      logic [N-1:0]         ev;
      logic [N-1:0]         eb;
      logic [N-1:0][DW-1:0] ed;
      logic [N-1:0][AW-1:0] dd;
      ev = VEC[v][15:8];
      eb = VEC[v][7:0];
      dd = VEC[v][39:16];
      ed = '0;
      // R1: each delivered payload sits on the port equal to its destination
      for (int i = 0; i < N; i++) begin
         if (VEC[v][40+i] && !eb[i]) ed[dd[i]] = dat_of(v, i);
      end
      check(req_of(v), $sformatf("vec%0d port_valid", v), 64'(port_valid), 64'(ev));
      check(req_of(v), $sformatf("vec%0d pkt_blocked", v), 64'(pkt_blocked), 64'(eb));
      check("R1", $sformatf("vec%0d port_data", v), 64'(port_data), 64'(ed));
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R6: inputs busy while reset held low
      drive(0);
      repeat (3) @(posedge clk);
      #5;
      check("R6", "reset port_valid", 64'(port_valid), 64'h0);
      check("R6", "reset port_data", 64'(port_data), 64'h0);
      check("R6", "reset pkt_blocked", 64'(pkt_blocked), 64'h0);

      @(negedge clk);
      pkt_valid = '0;
      rst_n = 1'b1;
      @(posedge clk);
      #5;
      check("R8", "idle after reset", 64'(port_valid), 64'h0);

      // table walk
      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         drive(v);
         if (v == 0) begin
            #5;
            // R1: nothing reaches the outputs before the clock edge
            check("R1", "no early output", 64'(port_valid), 64'h0);
         end
         @(posedge clk);
         #5;
         check_vec(v);
      end

      // R8: withdraw everything, results clear one cycle later
      @(negedge clk);
      pkt_valid = '0;
      @(posedge clk);
      #5;
      check("R8", "withdrawn port_valid", 64'(port_valid), 64'h0);
      check("R8", "withdrawn pkt_blocked", 64'(pkt_blocked), 64'h0);
      check("R4", "withdrawn port_data", 64'(port_data), 64'h0);

      // R5: mixed conflict load, conservation of valid inputs
      @(negedge clk);
      drive(6);
      @(posedge clk);
      #5;
      check("R5", "delivered plus blocked", 64'($countones(port_valid) + $countones(pkt_blocked)), 64'd8);

      // R6: asynchronous reset mid-run clears without a clock edge
      @(negedge clk);
      rst_n = 1'b0;
      #2;
      check("R6", "async reset port_valid", 64'(port_valid), 64'h0);
      check("R6", "async reset pkt_blocked", 64'(pkt_blocked), 64'h0);
      @(negedge clk);
      rst_n = 1'b1;
      pkt_valid = '0;
      @(posedge clk);
      #5;

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule